// File: doc/BRIEF.md
# Odd/Even Pixel Merger

This block takes two digitized pixel channels from a sensor readout. One channel carries the odd-numbered columns of a line and the other carries the even-numbered columns. The channels run at half the pixel rate, and their samples are offset from each other by half a channel period. The block combines them into one stream of pixels in column order, at twice the rate of a single channel.

The readout prepends a fixed number of dummy samples to every line on each channel. The block drops these samples. It also marks every output pixel by its position: the leftmost columns are dark-reference columns and the first rows of a frame are dark rows. Downstream black-level logic uses these marks, and the block performs no arithmetic on pixel values.

A channel may stop delivering samples partway through a line. The block then raises an error, stops its output for the rest of that line and starts again cleanly at the next line start.

Top module: `odd_even_merger`

## Requirements
- R1: The merged output alternates between the channels. Merged column 0 comes from the odd channel's first kept sample, column 1 from the even channel's first kept sample, and so on. Each channel's samples keep their arrival order.
- R2: On each channel, the first `DUMMY` samples after a line start are discarded and never appear at the output.
- R3: Each line produces exactly `2*HALF` merged pixels. Any channel sample beyond `DUMMY+HALF` in a line is ignored.
- R4: `px_dark` is high on merged columns 0 to `DARK_COLS-1` of every line and low on all other columns.
- R5: `px_active` is high only on a column at or above `DARK_COLS` in a row at or above `DARK_ROWS`. Row 0 is the line that carries `frame_start`, and the rows that follow it count up from there.
- R6: A kept sample appears on the output one clock after it is captured. If the channels alternate, or arrive in the same cycle, the `2*HALF` outputs of a line fall on consecutive clocks.
- R7: `px_sol` is high on merged column 0 of each line, and `px_sof` is high on merged column 0 of row 0. Neither flag is high without `px_valid`.
- R8: A channel with no valid sample for `MAX_GAP` consecutive clocks inside its line raises `err`. Output then stops until the next `line_start`, which clears `err`, and that next line is merged correctly.
- R9: While reset is held, `px_valid`, all output flags and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High in the cycle of the odd channel's first sample of a line |
| frame_start | input | 1 | High together with line_start on the first line of a frame |
| odd_valid | input | 1 | Odd-column channel sample strobe |
| odd_data | input | DW | Odd-column channel sample |
| even_valid | input | 1 | Even-column channel sample strobe |
| even_data | input | DW | Even-column channel sample |
| px_valid | output | 1 | Merged pixel strobe |
| px_data | output | DW | Merged pixel |
| px_sol | output | 1 | First pixel of a line |
| px_sof | output | 1 | First pixel of a frame |
| px_dark | output | 1 | Pixel is a dark-reference column |
| px_active | output | 1 | Pixel is in an active column of an active row |
| err | output | 1 | Missing-sample error, held until the next line start |

## Verification
Every sample carries its row and its true column, so every merged pixel is checked for both order and value. The merge is driven in two timing patterns. In the first, the even channel trails the odd channel by one clock. In the second, both channels arrive in the same cycle. Comparing the two shows whether the skew buffer, and not the input timing alone, produces the gap-free output.

One line carries surplus samples after its last real one, which shows that the per-line limit holds. In another line the even channel stops partway through. This separates error detection and flushing from the normal end of a line, and the line after it shows that recovery works. Two frames run back to back, so the dark-row and frame-start marks are tested for restarting.

// File: rtl/odd_even_merger.sv
module odd_even_merger #(
  parameter int DW        = 12,
  parameter int DUMMY     = 12,
  parameter int HALF      = 512,
  parameter int DARK_COLS = 24,
  parameter int LINES     = 512,
  parameter int DARK_ROWS = 2,
  parameter int MAX_GAP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          frame_start,
  input  logic          odd_valid,
  input  logic [DW-1:0] odd_data,
  input  logic          even_valid,
  input  logic [DW-1:0] even_data,
  output logic          px_valid,
  output logic [DW-1:0] px_data,
  output logic          px_sol,
  output logic          px_sof,
  output logic          px_dark,
  output logic          px_active,
  output logic          err
);
  localparam int PIX   = 2 * HALF;
  localparam int TOTAL = DUMMY + HALF;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam int CW    = $clog2(PIX + 1);
  localparam int RW    = $clog2(LINES);
  localparam int GW    = $clog2(MAX_GAP + 1);

  logic [1:0]    v;
  logic [DW-1:0] din  [2];
  logic [IW-1:0] idx  [2];
  logic [IW-1:0] cur  [2];
  logic [GW-1:0] gap  [2];
  logic [DW-1:0] slot [2];
  logic [1:0]    run, keep, full;
  logic          sel, gap_hit, kill, pop;
  logic [CW-1:0] ocol;
  logic [RW-1:0] row;

  assign v       = {even_valid, odd_valid};
  assign din[0]  = odd_data;
  assign din[1]  = even_data;

  always_comb begin
    gap_hit = 1'b0;
    for (int c = 0; c < 2; c++) begin
      cur[c]  = line_start ? '0 : idx[c];
      keep[c] = v[c] && (line_start || run[c]) &&
                (cur[c] >= IW'(DUMMY)) && (cur[c] < IW'(TOTAL));
      if (run[c] && !line_start && !v[c] && gap[c] == GW'(MAX_GAP - 1))
        gap_hit = 1'b1;
    end
  end

  assign kill = gap_hit || err;
  assign pop  = full[sel] && !kill && !line_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err       <= 1'b0;
      run       <= '0;
      full      <= '0;
      sel       <= 1'b0;
      ocol      <= '0;
      row       <= '0;
      px_valid  <= 1'b0;
      px_data   <= '0;
      px_sol    <= 1'b0;
      px_sof    <= 1'b0;
      px_dark   <= 1'b0;
      px_active <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        idx[c]  <= '0;
        gap[c]  <= '0;
        slot[c] <= '0;
      end
    end else begin
      if (line_start)   err <= 1'b0;
      else if (gap_hit) err <= 1'b1;

      for (int c = 0; c < 2; c++) begin
        if (line_start) begin
          idx[c] <= IW'(v[c]);
          run[c] <= 1'b1;
          gap[c] <= '0;
        end else if (run[c] && kill) begin
          run[c] <= 1'b0;
        end else if (run[c]) begin
          if (v[c]) begin
            idx[c] <= idx[c] + IW'(1);
            gap[c] <= '0;
            if (idx[c] == IW'(TOTAL - 1)) run[c] <= 1'b0;
          end else begin
            gap[c] <= gap[c] + GW'(1);
          end
        end

        if (line_start || kill) begin
          full[c] <= 1'b0;
        end else if (keep[c]) begin
          full[c] <= 1'b1;
          slot[c] <= din[c];
        end else if (pop && sel == c[0]) begin
          full[c] <= 1'b0;
        end
      end

      if (line_start || kill) sel <= 1'b0;
      else if (pop)           sel <= ~sel;

      if (line_start)  ocol <= '0;
      else if (pop)    ocol <= ocol + CW'(1);

      if (line_start)
        row <= frame_start ? '0 : (row == RW'(LINES - 1) ? row : row + RW'(1));

      px_valid  <= pop;
      px_data   <= slot[sel];
      px_sol    <= pop && ocol == '0;
      px_sof    <= pop && ocol == '0 && row == '0;
      px_dark   <= pop && ocol < CW'(DARK_COLS);
      px_active <= pop && ocol >= CW'(DARK_COLS) && row >= RW'(DARK_ROWS);
    end
  end

  assert_sof_on_sol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    px_sof |-> px_sol);
  assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid |-> !(px_sol || px_dark || px_active));
  assert_dark_not_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    px_dark |-> !px_active);
  assert_line_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> ocol <= CW'(PIX));
  assert_silent_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && $past(err)) |-> !px_valid);
endmodule

// File: tb/test_odd_even_merger.sv
`timescale 1ns/1ps
module test_odd_even_merger;
  localparam int DW = 12, DUMMY = 2, HALF = 6, DARK_COLS = 3, LINES = 4,
                 DARK_ROWS = 2, MAX_GAP = 4;
  localparam int PIX = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 1'b0, frame_start = 1'b0, odd_valid = 1'b0, even_valid = 1'b0;
  logic [DW-1:0] odd_data = '0, even_data = '0;
  logic px_valid, px_sol, px_sof, px_dark, px_active, err;
  logic [DW-1:0] px_data;

  odd_even_merger #(.DW(DW), .DUMMY(DUMMY), .HALF(HALF), .DARK_COLS(DARK_COLS),
    .LINES(LINES), .DARK_ROWS(DARK_ROWS), .MAX_GAP(MAX_GAP)) i_odd_even_merger (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .odd_valid(odd_valid), .odd_data(odd_data), .even_valid(even_valid),
    .even_data(even_data), .px_valid(px_valid), .px_data(px_data), .px_sol(px_sol),
    .px_sof(px_sof), .px_dark(px_dark), .px_active(px_active), .err(err));

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int m_row = 0, m_col = 0, m_first = 0, m_last = 0, cap = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && px_valid) begin
      int exp;
      exp = (m_row << 8) | m_col;
      check(int'(px_data) == exp, "R1/R2 data", int'(px_data), exp);
      check(px_dark == (m_col < DARK_COLS), "R4 dark", px_dark, m_col < DARK_COLS);
      check(px_active == (m_col >= DARK_COLS && m_row >= DARK_ROWS), "R5 active",
            px_active, m_col >= DARK_COLS && m_row >= DARK_ROWS);
      check(px_sol == (m_col == 0), "R7 sol", px_sol, m_col == 0);
      check(px_sof == (m_col == 0 && m_row == 0), "R7 sof", px_sof, m_col == 0 && m_row == 0);
      if (m_col == 0) m_first = cyc;
      m_last = cyc;
      m_col++;
    end
  end

  task automatic send_line(input int row, input bit frm, input bit skew,
                           input int drop_even, input int extra);
    int n;
    n = DUMMY + HALF + extra;
    m_row = row; m_col = 0; cap = -1;
    for (int t = 0; t < 2 * n + 2; t++) begin
      int k, ke;
      bit ev;
      @(negedge clk);
      line_start  = (t == 0);
      frame_start = (t == 0) && frm;
      k = t / 2;
      if (t % 2 == 0 && k < n) begin
        odd_valid = 1'b1;
        odd_data  = (k < DUMMY) ? 12'hFFF : {4'(row), 8'(2 * (k - DUMMY))};
        if (k == DUMMY) cap = cyc + 1;
      end else odd_valid = 1'b0;
      ke = skew ? (t - 1) / 2 : t / 2;
      ev = (skew ? (t % 2 == 1) : (t % 2 == 0)) && ke < n && ke < drop_even;
      even_valid = ev;
      even_data  = (ke < DUMMY) ? 12'hFFF : {4'(row), 8'(2 * (ke - DUMMY) + 1)};
    end
    @(negedge clk);
    line_start = 1'b0; frame_start = 1'b0; odd_valid = 1'b0; even_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic line_ok;
    check(m_col == PIX, "R3 pixels per line", m_col, PIX);
    check(m_last - m_first == PIX - 1, "R6 spacing", m_last - m_first, PIX - 1);
    check(m_first == cap + 1, "R6 latency", m_first, cap + 1);
    check(err == 1'b0, "R8 err clear", err, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(px_valid == 0, "R9 valid", px_valid, 0);
    check({px_sol, px_sof, px_dark, px_active} == 0, "R9 flags",
          {px_sol, px_sof, px_dark, px_active}, 0);
    check(err == 0, "R9 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      send_line(r, r == 0, 1'b1, 1000, (r == 1) ? 2 : 0);
      line_ok();
    end

    send_line(0, 1'b1, 1'b0, 1000, 0); line_ok();
    send_line(1, 1'b0, 1'b0, 1000, 0); line_ok();
    send_line(2, 1'b0, 1'b0, DUMMY + 2, 0);
    check(err == 1'b1, "R8 err raised", err, 1);
    check(m_col > 0 && m_col < PIX, "R8 output stopped", m_col, PIX - 1);
    send_line(3, 1'b0, 1'b0, 1000, 0); line_ok();

    summary();
  end
endmodule